// File: doc/BRIEF.md
# Dual-Bus Transceiver Host Register Port

This block is the host-facing register port of a serial transceiver core that serves two redundant buses, A and B. A host processor reaches it through an active-low strobe, a read/write line, a register-select line and a 16-bit bidirectional data bus. A bidirectional sync line acts as a seventeenth data bit. When register select is low, a write hands a word to the encoder and a read returns the stored word of one receiver. When register select is high, the cycle reaches a 16-bit status word. The low six bits of the status word hold configuration. The upper bits report the state of both receivers and the transmit window.

The host control lines are asynchronous to the core clock. They pass through a synchronizer, and a cycle takes effect on the rising edge of the strobe. The bus choice and the sync type can come from the configuration bits or from two pins, because each pin is ORed with its configuration bit. The encoder and the two decoders sit outside the block. The encoder receives a one-cycle load pulse. Each decoder delivers valid and error pulses together with its word and sync type.

Top module: `hostRegPort`

## Requirements
- R1: While `masterReset` is high, `coreInit` is high. One clock after reset, the status word reads 0x000C, both stored receive words read 0, and `rcvFlag` and `errorOut` are low.
- R2: A write with `regSel`=1 updates only status bits 5:0. Bits 15:6 are read-only, and bit 6 always reads 0.
- R3: Status layout. Bits 7, 8, 9 and 10 are the bus A receive flag, the received sync, the idle state (`rxIdle[0]`) and the error flag. Bits 11 to 14 hold the same four fields for bus B. Bit 15 mirrors `sendWindow`.
- R4: A write with `regSel`=0 produces exactly one `txLoad` pulse. The pulse carries the written word. `txSyncCmd` equals the sync line OR status bit 4. `txBusB` equals `chanPin` OR status bit 5.
- R5: A read with `regSel`=0 returns the receive B word when `chanPin` OR bit 5 is 1, and the receive A word otherwise. On that read, the sync line carries the stored sync of the chosen bus. On a status read, the sync line carries 0.
- R6: Reading a receive word clears the receive flag of that bus only.
- R7: When a bus is enabled, a `rxValid` pulse on it stores the word and the sync and sets the bus's `rcvFlag`.
- R8: When a bus is disabled (bit 2 clear for A, bit 3 clear for B), its valid and error pulses change no flag, no stored word and not `errorOut`.
- R9: An error pulse on an enabled bus sets that bus's error flag. The next valid word on the same bus clears it. `errorOut` is the OR of both error flags.
- R10: The block drives `dataBus` and `syncLine` only while `strobeN` is low and `readNotWrite` is high. At all other times they are high-impedance.
- R11: A write commits on the third clock edge after the strobe rises. Data, sync, select and read/write must stay stable and the strobe must stay high until that edge. `txDisable` equals bits 1:0 and `rxEnable` equals bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| masterReset | input | 1 | Synchronous active-high master reset |
| strobeN | input | 1 | Host strobe, active low; a cycle commits on its rising edge |
| readNotWrite | input | 1 | 1 = read cycle, 0 = write cycle |
| regSel | input | 1 | 1 = status word, 0 = transmit/receive words |
| chanPin | input | 1 | Bus select pin, ORed with status bit 5 |
| dataBus | inout | 16 | Host data bus |
| syncLine | inout | 1 | Sync bit: input on writes, output on reads |
| rxValid | input | 2 | Decoder valid-word pulses, [0]=A, [1]=B |
| rxWordA | input | 16 | Decoded word of bus A |
| rxWordB | input | 16 | Decoded word of bus B |
| rxSync | input | 2 | Received sync type per bus, 1 = command |
| rxError | input | 2 | Decoder error pulses per bus |
| rxIdle | input | 2 | Bus idle indication per bus |
| sendWindow | input | 1 | Encoder ready-for-next-word window |
| txLoad | output | 1 | One-cycle load pulse to the encoder |
| txWord | output | 16 | Word to transmit |
| txSyncCmd | output | 1 | 1 = command sync, 0 = data sync |
| txBusB | output | 1 | 1 = transmit on bus B, 0 = bus A |
| txDisable | output | 2 | Transmitter disables, [0]=A, [1]=B |
| rxEnable | output | 2 | Receiver enables, [0]=A, [1]=B |
| rcvFlag | output | 2 | Word-received flags per bus |
| errorOut | output | 1 | OR of the two error flags |
| coreInit | output | 1 | Initialize request to encoder and decoders |

## Verification
Four properties are checked on every cycle. The encoder load is a single-cycle pulse. A receive flag or the error output can rise only after an enabled decoder pulse, and a disabled bus leaves its flag low. The configuration outputs change only after reset or after a strobe that is already high again. The bench scenarios cover everything that depends on data values: the status field layout, the ORing of pins with configuration bits, the choice of receive word and the sync value returned with it, per-bus clearing on read, release of the bus while the strobe is high, and the values after a master reset.

// File: rtl/hostPortPkg.sv
package hostPortPkg;
  localparam int WORD_W      = 16;
  localparam int CFG_W       = 6;
  localparam int NUM_BUS     = 2;
  localparam int CTRL_W      = 4;

  // configuration bit positions (low bits of the status word)
  localparam int CFG_TXDIS_A = 0;
  localparam int CFG_TXDIS_B = 1;
  localparam int CFG_RXEN_A  = 2;
  localparam int CFG_RXEN_B  = 3;
  localparam int CFG_SYNC    = 4;
  localparam int CFG_CHAN    = 5;

  localparam logic [CFG_W-1:0] CFG_DEFAULT = 6'b001100;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic loadTx;
    logic loadCfg;
    logic clearRxA;
    logic clearRxB;
    logic chanPinSync;
  } ctrlStrobes_t;
endpackage

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostPortPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic         clk,
  input  logic         masterReset,
  input  logic         strobeN,
  input  logic         readNotWrite,
  input  logic         regSel,
  input  logic         chanPin,
  input  logic         chanCfg,
  output ctrlStrobes_t strobes
);
  // bundle order: {strobeN, readNotWrite, regSel, chanPin}
  localparam logic [CTRL_W-1:0] IDLE_CTRL = 4'b1100;
  localparam int STB = 3;
  localparam int RW  = 2;
  localparam int SEL = 1;
  localparam int CH  = 0;

  logic [CTRL_W-1:0] rawCtrl;
  logic [CTRL_W-1:0] syncPipe [SyncStages];
  logic [CTRL_W-1:0] ctrlSync;
  logic              strobePrev;
  logic              strobeRise;
  logic              effChan;

  assign rawCtrl = {strobeN, readNotWrite, regSel, chanPin};

  for (genvar i = 0; i < SyncStages; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (masterReset) syncPipe[i] <= IDLE_CTRL;
        else             syncPipe[i] <= rawCtrl;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (masterReset) syncPipe[i] <= IDLE_CTRL;
        else             syncPipe[i] <= syncPipe[i-1];
      end
    end
  end

  assign ctrlSync = syncPipe[SyncStages-1];

  always_ff @(posedge clk) begin
    if (masterReset) strobePrev <= 1'b1;
    else             strobePrev <= ctrlSync[STB];
  end

  assign strobeRise = ctrlSync[STB] & ~strobePrev;
  assign effChan    = ctrlSync[CH] | chanCfg;

  always_comb begin
    strobes             = '0;
    strobes.chanPinSync = ctrlSync[CH];
    if (strobeRise) begin
      if (!ctrlSync[RW]) begin
        strobes.loadTx  = ~ctrlSync[SEL];
        strobes.loadCfg = ctrlSync[SEL];
      end else if (!ctrlSync[SEL]) begin
        strobes.clearRxA = ~effChan;
        strobes.clearRxB = effChan;
      end
    end
  end
endmodule

// File: rtl/hostPortData.sv
module hostPortData
  import hostPortPkg::*;
#(
  parameter int DataW = WORD_W
) (
  input  logic                clk,
  input  logic                masterReset,
  input  ctrlStrobes_t        strobes,
  input  logic [DataW-1:0]    dataIn,
  input  logic                syncIn,
  input  logic                rawRegSel,
  input  logic                rawChanPin,
  input  logic [NUM_BUS-1:0]  rxValid,
  input  logic [DataW-1:0]    rxWordA,
  input  logic [DataW-1:0]    rxWordB,
  input  logic [NUM_BUS-1:0]  rxSync,
  input  logic [NUM_BUS-1:0]  rxError,
  input  logic [NUM_BUS-1:0]  rxIdle,
  input  logic                sendWindow,
  output logic [DataW-1:0]    readWord,
  output logic                readSync,
  output logic                chanCfg,
  output logic                txLoad,
  output logic [DataW-1:0]    txWord,
  output logic                txSyncCmd,
  output logic                txBusB,
  output logic [NUM_BUS-1:0]  txDisable,
  output logic [NUM_BUS-1:0]  rxEnable,
  output logic [NUM_BUS-1:0]  rcvFlag,
  output logic                errorOut
);
  logic [CFG_W-1:0]   cfgQ;
  logic [DataW-1:0]   rxWordIn [NUM_BUS];
  logic [DataW-1:0]   rxWordQ  [NUM_BUS];
  logic [NUM_BUS-1:0] rxSyncQ;
  logic [NUM_BUS-1:0] flagQ;
  logic [NUM_BUS-1:0] errQ;
  logic [NUM_BUS-1:0] clearRx;
  logic [15:0]        statusWord;
  logic               rawEffChan;

  // configuration register
  always_ff @(posedge clk) begin
    if (masterReset)          cfgQ <= CFG_DEFAULT;
    else if (strobes.loadCfg) cfgQ <= dataIn[CFG_W-1:0];
  end

  assign chanCfg   = cfgQ[CFG_CHAN];
  assign txDisable = {cfgQ[CFG_TXDIS_B], cfgQ[CFG_TXDIS_A]};
  assign rxEnable  = {cfgQ[CFG_RXEN_B], cfgQ[CFG_RXEN_A]};

  // transmit hand-off
  always_ff @(posedge clk) begin
    if (masterReset) begin
      txLoad    <= 1'b0;
      txWord    <= '0;
      txSyncCmd <= 1'b0;
      txBusB    <= 1'b0;
    end else begin
      txLoad <= strobes.loadTx;
      if (strobes.loadTx) begin
        txWord    <= dataIn;
        txSyncCmd <= syncIn | cfgQ[CFG_SYNC];
        txBusB    <= strobes.chanPinSync | cfgQ[CFG_CHAN];
      end
    end
  end

  // per-bus receive storage
  assign rxWordIn[0] = rxWordA;
  assign rxWordIn[1] = rxWordB;
  assign clearRx     = {strobes.clearRxB, strobes.clearRxA};

  for (genvar b = 0; b < NUM_BUS; b++) begin : gBus
    logic takeWord;
    logic takeErr;
    assign takeWord = rxValid[b] & rxEnable[b];
    assign takeErr  = rxError[b] & rxEnable[b];

    always_ff @(posedge clk) begin
      if (masterReset) begin
        rxWordQ[b] <= '0;
        rxSyncQ[b] <= 1'b0;
      end else if (takeWord) begin
        rxWordQ[b] <= rxWordIn[b];
        rxSyncQ[b] <= rxSync[b];
      end
    end

    always_ff @(posedge clk) begin
      if (masterReset)     flagQ[b] <= 1'b0;
      else if (takeWord)   flagQ[b] <= 1'b1;
      else if (clearRx[b]) flagQ[b] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (masterReset)   errQ[b] <= 1'b0;
      else if (takeErr)  errQ[b] <= 1'b1;
      else if (takeWord) errQ[b] <= 1'b0;
    end
  end

  assign rcvFlag  = flagQ;
  assign errorOut = |errQ;

  // status word: per-bus nibble {err, idle, sync, flag}
  assign statusWord = {sendWindow,
                       errQ[1], rxIdle[1], rxSyncQ[1], flagQ[1],
                       errQ[0], rxIdle[0], rxSyncQ[0], flagQ[0],
                       1'b0, cfgQ};

  // read path follows the raw pins so data is ready while strobe is low
  assign rawEffChan = rawChanPin | cfgQ[CFG_CHAN];

  always_comb begin
    if (rawRegSel) begin
      readWord = statusWord[DataW-1:0];
      readSync = 1'b0;
    end else begin
      readWord = rxWordQ[rawEffChan];
      readSync = rxSyncQ[rawEffChan];
    end
  end
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hostPortPkg::*;
#(
  parameter int DataW      = WORD_W,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               masterReset,
  input  logic               strobeN,
  input  logic               readNotWrite,
  input  logic               regSel,
  input  logic               chanPin,
  inout  wire  [DataW-1:0]   dataBus,
  inout  wire                syncLine,
  input  logic [1:0]         rxValid,
  input  logic [DataW-1:0]   rxWordA,
  input  logic [DataW-1:0]   rxWordB,
  input  logic [1:0]         rxSync,
  input  logic [1:0]         rxError,
  input  logic [1:0]         rxIdle,
  input  logic               sendWindow,
  output logic               txLoad,
  output logic [DataW-1:0]   txWord,
  output logic               txSyncCmd,
  output logic               txBusB,
  output logic [1:0]         txDisable,
  output logic [1:0]         rxEnable,
  output logic [1:0]         rcvFlag,
  output logic               errorOut,
  output logic               coreInit
);
  ctrlStrobes_t      strobes;
  logic              chanCfg;
  logic [DataW-1:0]  readWord;
  logic              readSync;
  logic              readOe;

  hostPortCtrl #(.SyncStages(SyncStages)) uCtrl (
    .clk          (clk),
    .masterReset  (masterReset),
    .strobeN      (strobeN),
    .readNotWrite (readNotWrite),
    .regSel       (regSel),
    .chanPin      (chanPin),
    .chanCfg      (chanCfg),
    .strobes      (strobes)
  );

  hostPortData #(.DataW(DataW)) uData (
    .clk         (clk),
    .masterReset (masterReset),
    .strobes     (strobes),
    .dataIn      (dataBus),
    .syncIn      (syncLine),
    .rawRegSel   (regSel),
    .rawChanPin  (chanPin),
    .rxValid     (rxValid),
    .rxWordA     (rxWordA),
    .rxWordB     (rxWordB),
    .rxSync      (rxSync),
    .rxError     (rxError),
    .rxIdle      (rxIdle),
    .sendWindow  (sendWindow),
    .readWord    (readWord),
    .readSync    (readSync),
    .chanCfg     (chanCfg),
    .txLoad      (txLoad),
    .txWord      (txWord),
    .txSyncCmd   (txSyncCmd),
    .txBusB      (txBusB),
    .txDisable   (txDisable),
    .rxEnable    (rxEnable),
    .rcvFlag     (rcvFlag),
    .errorOut    (errorOut)
  );

  assign readOe   = ~strobeN & readNotWrite;
  assign dataBus  = readOe ? readWord : {DataW{1'bz}};
  assign syncLine = readOe ? readSync : 1'bz;
  assign coreInit = masterReset;
endmodule

// File: rtl/hostRegPortChk.sv
module hostRegPortChk (
  input logic       clk,
  input logic       masterReset,
  input logic       strobeN,
  input logic       txLoad,
  input logic [1:0] rxValid,
  input logic [1:0] rxError,
  input logic [1:0] rxEnable,
  input logic [1:0] txDisable,
  input logic [1:0] rcvFlag,
  input logic       errorOut
);
  logic resetSeen;
  always_ff @(posedge clk) resetSeen <= masterReset;

  // R1: state directly after a reset clock
  always @(posedge clk) begin
    if (resetSeen === 1'b1) begin
      a_r1_reset_defaults: assert (txDisable == 2'b00 && rxEnable == 2'b11 &&
                                   rcvFlag == 2'b00 && !errorOut);
    end
  end

  a_r4_load_single: assert property (@(posedge clk) disable iff (masterReset)
    txLoad |=> !txLoad);

  a_r7_flag_a_cause: assert property (@(posedge clk) disable iff (masterReset)
    $rose(rcvFlag[0]) |-> $past(rxValid[0] && rxEnable[0]));

  a_r7_flag_b_cause: assert property (@(posedge clk) disable iff (masterReset)
    $rose(rcvFlag[1]) |-> $past(rxValid[1] && rxEnable[1]));

  a_r8_disabled_a_quiet: assert property (@(posedge clk) disable iff (masterReset)
    (!rxEnable[0] && !rcvFlag[0]) |=> !rcvFlag[0]);

  a_r9_error_cause: assert property (@(posedge clk) disable iff (masterReset)
    $rose(errorOut) |-> $past(|(rxError & rxEnable)));

  a_r11_cfg_after_strobe: assert property (@(posedge clk) disable iff (masterReset)
    (!$stable(rxEnable) || !$stable(txDisable)) |-> ($past(masterReset) || $past(strobeN)));
endmodule

bind hostRegPort hostRegPortChk uChk (
  .clk         (clk),
  .masterReset (masterReset),
  .strobeN     (strobeN),
  .txLoad      (txLoad),
  .rxValid     (rxValid),
  .rxError     (rxError),
  .rxEnable    (rxEnable),
  .txDisable   (txDisable),
  .rcvFlag     (rcvFlag),
  .errorOut    (errorOut)
);

// File: tb/sim_hostRegPort.sv
module sim_hostRegPort;
  logic        clk = 1'b0;
  logic        masterReset = 1'b1;
  logic        strobeN = 1'b1;
  logic        readNotWrite = 1'b1;
  logic        regSel = 1'b0;
  logic        chanPin = 1'b0;
  logic [15:0] tbDrive = '0;
  logic        tbSync = 1'b0;
  logic        tbOe = 1'b0;
  wire  [15:0] dataBus;
  wire         syncLine;
  logic [1:0]  rxValid = '0;
  logic [15:0] rxWordA = '0;
  logic [15:0] rxWordB = '0;
  logic [1:0]  rxSync = '0;
  logic [1:0]  rxError = '0;
  logic [1:0]  rxIdle = '0;
  logic        sendWindow = 1'b0;
  logic        txLoad;
  logic [15:0] txWord;
  logic        txSyncCmd;
  logic        txBusB;
  logic [1:0]  txDisable;
  logic [1:0]  rxEnable;
  logic [1:0]  rcvFlag;
  logic        errorOut;
  logic        coreInit;

  int checks = 0;
  int failures = 0;
  int loadCount = 0;
  logic [15:0] lastWord = '0;
  logic        lastSync = 1'b0;
  logic        lastBus = 1'b0;
  bit          finished = 1'b0;

  assign dataBus  = tbOe ? tbDrive : 16'hzzzz;
  assign syncLine = tbOe ? tbSync : 1'bz;

  always #10 clk = ~clk;

  hostRegPort u0 (
    .clk(clk), .masterReset(masterReset), .strobeN(strobeN),
    .readNotWrite(readNotWrite), .regSel(regSel), .chanPin(chanPin),
    .dataBus(dataBus), .syncLine(syncLine), .rxValid(rxValid),
    .rxWordA(rxWordA), .rxWordB(rxWordB), .rxSync(rxSync),
    .rxError(rxError), .rxIdle(rxIdle), .sendWindow(sendWindow),
    .txLoad(txLoad), .txWord(txWord), .txSyncCmd(txSyncCmd),
    .txBusB(txBusB), .txDisable(txDisable), .rxEnable(rxEnable),
    .rcvFlag(rcvFlag), .errorOut(errorOut), .coreInit(coreInit)
  );

  always @(negedge clk) begin
    if (txLoad === 1'b1) begin
      loadCount++;
      lastWord = txWord;
      lastSync = txSyncCmd;
      lastBus  = txBusB;
    end
  end

  // {value written to status, value expected back}
  localparam logic [31:0] CFG_TABLE [5] = '{
    {16'h003F, 16'h003F},
    {16'hFFC0, 16'h0000},
    {16'h0015, 16'h0015},
    {16'h002A, 16'h002A},
    {16'h000C, 16'h000C}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic ch, input logic s, input logic [15:0] d);
    @(negedge clk);
    readNotWrite = 1'b0; regSel = sel; chanPin = ch;
    tbDrive = d; tbSync = s; tbOe = 1'b1; strobeN = 1'b0;
    repeat (3) @(negedge clk);
    strobeN = 1'b1;
    repeat (4) @(negedge clk);
    tbOe = 1'b0; readNotWrite = 1'b1;
  endtask

  task automatic hostRead(input logic sel, input logic ch, output logic [15:0] d, output logic s);
    @(negedge clk);
    readNotWrite = 1'b1; regSel = sel; chanPin = ch; strobeN = 1'b0;
    #5;
    d = dataBus; s = syncLine;
    @(negedge clk);
    strobeN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rxPulse(input int b, input logic [15:0] w, input logic s);
    @(negedge clk);
    if (b == 0) rxWordA = w; else rxWordB = w;
    rxSync[b] = s; rxValid[b] = 1'b1;
    @(negedge clk);
    rxValid = '0;
    @(negedge clk);
  endtask

  task automatic errPulse(input int b);
    @(negedge clk);
    rxError[b] = 1'b1;
    @(negedge clk);
    rxError = '0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    logic        rs;
    repeat (3) @(negedge clk);
    check(coreInit === 1'b1, "R1 init", {31'd0, coreInit}, 32'd1);
    masterReset = 1'b0;
    @(negedge clk);
    hostRead(1'b1, 1'b0, rd, rs);
    check(rd === 16'h000C, "R1 status", {16'd0, rd}, 32'h000C);
    hostRead(1'b0, 1'b0, rd, rs);
    check(rd === 16'h0000, "R1 rxA", {16'd0, rd}, 32'd0);
    check(rcvFlag === 2'b00 && errorOut === 1'b0, "R1 flags", {29'd0, errorOut, rcvFlag}, 32'd0);
    check(dataBus === 16'hzzzz && syncLine === 1'bz, "R10 idle release", {15'd0, syncLine, dataBus}, 32'h0);

    // R2 / R11 table walk
    foreach (CFG_TABLE[i]) begin
      hostWrite(1'b1, 1'b0, 1'b0, CFG_TABLE[i][31:16]);
      hostRead(1'b1, 1'b0, rd, rs);
      check(rd === CFG_TABLE[i][15:0], "R2 config readback", {16'd0, rd}, {16'd0, CFG_TABLE[i][15:0]});
      check(txDisable === CFG_TABLE[i][1:0] && rxEnable === CFG_TABLE[i][3:2], "R11 config pins",
            {28'd0, rxEnable, txDisable}, {28'd0, CFG_TABLE[i][3:0]});
    end

    // R4 transmit writes
    hostWrite(1'b0, 1'b0, 1'b1, 16'hA5A5);
    check(loadCount == 1 && lastWord === 16'hA5A5 && lastSync && !lastBus, "R4 tx sync pin",
          {lastBus, lastSync, 14'd0, lastWord}, {2'b01, 14'd0, 16'hA5A5});
    hostWrite(1'b1, 1'b0, 1'b0, 16'h002C);
    hostWrite(1'b0, 1'b0, 1'b0, 16'h1357);
    check(loadCount == 2 && lastWord === 16'h1357 && !lastSync && lastBus, "R4 tx chan bit",
          {lastBus, lastSync, 14'd0, lastWord}, {2'b10, 14'd0, 16'h1357});
    hostWrite(1'b1, 1'b0, 1'b0, 16'h001C);
    hostWrite(1'b0, 1'b1, 1'b0, 16'h00FF);
    check(loadCount == 3 && lastSync && lastBus, "R4 tx sync bit and pin",
          {30'd0, lastBus, lastSync}, 32'd3);
    hostWrite(1'b1, 1'b0, 1'b0, 16'h000C);

    // R7 / R3 / R5 / R6 receive A
    rxPulse(0, 16'h1234, 1'b1);
    check(rcvFlag === 2'b01, "R7 flag A", {30'd0, rcvFlag}, 32'd1);
    hostRead(1'b1, 1'b0, rd, rs);
    check(rd === 16'h018C, "R3 status A fields", {16'd0, rd}, 32'h018C);
    check(rs === 1'b0, "R5 status sync", {31'd0, rs}, 32'd0);
    hostRead(1'b0, 1'b0, rd, rs);
    check(rd === 16'h1234 && rs === 1'b1, "R5 read A", {15'd0, rs, rd}, {15'd0, 1'b1, 16'h1234});
    check(rcvFlag === 2'b00, "R6 clear A", {30'd0, rcvFlag}, 32'd0);

    // R6 per-bus clear, R5 select by pin
    rxPulse(0, 16'h4444, 1'b0);
    rxPulse(1, 16'hBEEF, 1'b0);
    hostRead(1'b0, 1'b1, rd, rs);
    check(rd === 16'hBEEF && rs === 1'b0, "R5 read B", {15'd0, rs, rd}, {16'd0, 16'hBEEF});
    check(rcvFlag === 2'b01, "R6 clear B only", {30'd0, rcvFlag}, 32'd1);
    hostRead(1'b0, 1'b0, rd, rs);
    check(rd === 16'h4444 && rcvFlag === 2'b00, "R6 read A after", {14'd0, rcvFlag, rd}, {16'd0, 16'h4444});

    // R3 idle and window fields
    rxIdle = 2'b11; sendWindow = 1'b1;
    hostRead(1'b1, 1'b0, rd, rs);
    check(rd === 16'hA20C, "R3 idle window", {16'd0, rd}, 32'hA20C);
    rxIdle = 2'b00; sendWindow = 1'b0;

    // R8 disabled receiver A
    hostWrite(1'b1, 1'b0, 1'b0, 16'h0008);
    rxPulse(0, 16'h5555, 1'b1);
    check(rcvFlag === 2'b00, "R8 no flag", {30'd0, rcvFlag}, 32'd0);
    errPulse(0);
    check(errorOut === 1'b0, "R8 no error", {31'd0, errorOut}, 32'd0);
    hostRead(1'b0, 1'b0, rd, rs);
    check(rd === 16'h4444, "R8 word kept", {16'd0, rd}, 32'h4444);
    hostWrite(1'b1, 1'b0, 1'b0, 16'h000C);

    // R9 error on B
    errPulse(1);
    check(errorOut === 1'b1, "R9 error set", {31'd0, errorOut}, 32'd1);
    hostRead(1'b1, 1'b0, rd, rs);
    check(rd === 16'h400C, "R9 status error B", {16'd0, rd}, 32'h400C);
    rxPulse(1, 16'h0F0F, 1'b1);
    check(errorOut === 1'b0 && rcvFlag === 2'b10, "R9 error cleared", {29'd0, errorOut, rcvFlag}, 32'd2);

    // R1 master reset after traffic
    @(negedge clk); masterReset = 1'b1;
    repeat (2) @(negedge clk); masterReset = 1'b0;
    hostRead(1'b0, 1'b1, rd, rs);
    check(rd === 16'h0000 && rs === 1'b0, "R1 rxB cleared", {15'd0, rs, rd}, 32'd0);
    hostRead(1'b1, 1'b0, rd, rs);
    check(rd === 16'h000C, "R1 status after reset", {16'd0, rd}, 32'h000C);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule